// File: doc/BRIEF.md
# AND-OR Match Reduction Row

This block is one row of a match-style array of the kind found in translation buffers and content-addressable tag stores. Each column of the row keeps a single stored qualifier bit. The qualifier is loaded when that column's write select is high. When the write select is low, the qualifier feeds back to itself through a select mux and keeps its value. Every column also takes a group of data terms. The column ANDs each term with its qualifier and with a select line shared by the whole row. A balanced OR tree reduces the resulting products to one bit.

The tree output is ORed with a set-override line that is also shared by the row, and the result goes into a registered hit bit in every cycle. A high override forces every column's hit bit to 1 at the next edge, whatever the data. The default build has four columns of sixteen terms each. A full array uses this row many times, with 257 columns and 32 rows. Both state bits are rising-edge registers. A synchronous active-high reset clears them.

Top module: `andor_match_row`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears every qualifier bit and every `hit_q` bit to 0, even if `force_set` is high.
- R2: When `wr_sel[c]` is high at an edge, column c's qualifier takes the value of `qual_din[c]`.
- R3: When `wr_sel[c]` is low at an edge, column c's qualifier keeps its value, and `qual_din[c]` has no effect on later `hit_q[c]` values.
- R4: `hit_q[c]` after an edge equals the OR over t of (`term_in[c*TERMS+t]` AND qualifier[c] AND `row_sel`), ORed with `force_set`. All of these are the values sampled at that edge.
- R5: With `row_sel` low and `force_set` low at an edge, every `hit_q` bit is 0 after that edge.
- R6: A column whose qualifier is 0 gives `hit_q` = 0 after the edge unless `force_set` is high.
- R7: With `force_set` high at an edge outside reset, every `hit_q` bit is 1 after that edge.
- R8: The edge that writes a qualifier computes `hit_q` from the qualifier value held before that edge.
- R9: `hit_q` is not sticky. An edge with no active product term and `force_set` low returns the bit to 0.
- R10: Term bit `term_in[c*TERMS+t]` affects only `hit_q[c]`. Columns do not interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_sel | input | COLS | Per-column qualifier write select |
| qual_din | input | COLS | Per-column qualifier write data |
| row_sel | input | 1 | Row-wide select ANDed into every product term |
| force_set | input | 1 | Row-wide override that sets every hit bit |
| term_in | input | COLS*TERMS | Data terms, column c at bits c*TERMS..c*TERMS+TERMS-1 |
| hit_q | output | COLS | Registered per-column hit |

## Verification
The qualifier has no port of its own. Its hold and load behaviour shows up only when terms and the row select let it pass into `hit_q`. Whenever the bench changes `qual_din` while the write select is low, it follows up at once with an all-ones term pattern and the select high, so any corrupted qualifier shows on the output. The same-edge write case, where the output must still use the old qualifier, needs a write and an enabled term pattern in one cycle. The bench then repeats the pattern one cycle later to see the new value take effect.

// File: rtl/andor_pkg.sv
package andor_pkg;

  localparam int unsigned COLS_DEF  = 4;
  localparam int unsigned TERMS_DEF = 16;

  // Final stage of a column: the reduced match merged with the override.
  function automatic logic merge_override(input logic any_term, input logic force_set);
    return any_term | force_set;
  endfunction

  // Recirculating select in front of the qualifier register.
  function automatic logic qual_next(input logic wr_en, input logic din, input logic held);
    return wr_en ? din : held;
  endfunction

endpackage

// File: rtl/or_tree.sv
module or_tree #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] leaves,
  output logic             root
);

  localparam int unsigned LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int unsigned PADDED = 1 << LEVELS;

  // Pairwise reduction, halving the live width each level.
  function automatic logic reduce_pairs(input logic [PADDED-1:0] x);
    logic [PADDED-1:0] t;
    t = x;
    for (int span = PADDED / 2; span >= 1; span = span / 2) begin
      for (int i = 0; i < span; i++) begin
        t[i] = t[2*i] | t[2*i+1];
      end
    end
    return t[0];
  endfunction

  logic [PADDED-1:0] padded;

  always_comb begin
    padded = '0;
    padded[WIDTH-1:0] = leaves;
  end

  assign root = reduce_pairs(padded);

endmodule

// File: rtl/qual_cell.sv
module qual_cell (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic din,
  output logic qual_q
);
  import andor_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) qual_q <= 1'b0;
    else     qual_q <= qual_next(wr_en, din, qual_q);
  end

  // R2: a write select loads the data bit
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (qual_q == $past(din)));

  // R3: without a write select the stored bit is held
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(qual_q));

endmodule

// File: rtl/match_column.sv
module match_column #(
  parameter int unsigned TERMS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             qual_din,
  input  logic             row_sel,
  input  logic             force_set,
  input  logic [TERMS-1:0] terms,
  output logic             hit_q
);
  import andor_pkg::*;

  logic             qual_q;
  logic [TERMS-1:0] products;
  logic             any_term;
  logic             hit_next;

  qual_cell u_qual (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .din    (qual_din),
    .qual_q (qual_q)
  );

  genvar t;
  generate
    for (t = 0; t < TERMS; t++) begin : g_prod
      assign products[t] = terms[t] & qual_q & row_sel;
    end
  endgenerate

  or_tree #(.WIDTH(TERMS)) u_tree (
    .leaves (products),
    .root   (any_term)
  );

  assign hit_next = merge_override(any_term, force_set);

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit_next;
  end

  // R4: an active product term yields a hit
  a_r4_term_hits: assert property (@(posedge clk) disable iff (rst)
    any_term |=> hit_q);

  // R5: select low without override blocks the column
  a_r5_sel_blocks: assert property (@(posedge clk) disable iff (rst)
    (!row_sel && !force_set) |=> !hit_q);

  // R6: a cleared qualifier masks every term
  a_r6_qual_masks: assert property (@(posedge clk) disable iff (rst)
    (!qual_q && !force_set) |=> !hit_q);

  // R7: the override sets the hit bit
  a_r7_force_sets: assert property (@(posedge clk) disable iff (rst)
    force_set |=> hit_q);

  // R9: with no term and no override the bit drops
  a_r9_not_sticky: assert property (@(posedge clk) disable iff (rst)
    (!any_term && !force_set) |=> !hit_q);

endmodule

// File: rtl/andor_match_row.sv
module andor_match_row #(
  parameter int unsigned COLS  = andor_pkg::COLS_DEF,
  parameter int unsigned TERMS = andor_pkg::TERMS_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [COLS-1:0]       wr_sel,
  input  logic [COLS-1:0]       qual_din,
  input  logic                  row_sel,
  input  logic                  force_set,
  input  logic [COLS*TERMS-1:0] term_in,
  output logic [COLS-1:0]       hit_q
);

  localparam int unsigned TERM_BITS = COLS * TERMS;

  logic [TERM_BITS-1:0] term_bus;
  assign term_bus = term_in;

  genvar c;
  generate
    for (c = 0; c < COLS; c++) begin : g_col
      match_column #(.TERMS(TERMS)) u_col (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_sel[c]),
        .qual_din  (qual_din[c]),
        .row_sel   (row_sel),
        .force_set (force_set),
        .terms     (term_bus[c*TERMS +: TERMS]),
        .hit_q     (hit_q[c])
      );
    end
  endgenerate

  // R1: reset clears the output regardless of the override
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (hit_q == '0));

  // R7: override sets all columns together
  a_r7_all_set: assert property (@(posedge clk) disable iff (rst)
    force_set |=> (hit_q == {COLS{1'b1}}));

endmodule

// File: tb/test_andor_match_row.sv
`timescale 1ns/1ps
module test_andor_match_row;

  localparam int COLS  = 4;
  localparam int TERMS = 16;
  localparam int TB    = COLS * TERMS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [COLS-1:0] wr_sel = '0;
  logic [COLS-1:0] qual_din = '0;
  logic            row_sel = 1'b0;
  logic            force_set = 1'b0;
  logic [TB-1:0]   term_in = '0;
  logic [COLS-1:0] hit_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [COLS-1:0] qual_m = '0;
  logic [COLS-1:0] hit_m  = '0;

  always #4 clk = ~clk;

  andor_match_row #(.COLS(COLS), .TERMS(TERMS)) i_andor_match_row (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .qual_din(qual_din),
    .row_sel(row_sel), .force_set(force_set), .term_in(term_in), .hit_q(hit_q)
  );

  task automatic check(input string req, input logic [COLS-1:0] exp);
    total++;
    if (hit_q !== exp) begin
      bad++;
      $display("FAIL %s hit_q=%b expected=%b", req, hit_q, exp);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge.
  task automatic cyc(input logic r, input logic [COLS-1:0] we, input logic [COLS-1:0] din,
                     input logic sd, input logic ei, input logic [TB-1:0] terms,
                     input string req);
    rst = r; wr_sel = we; qual_din = din; row_sel = sd; force_set = ei; term_in = terms;
    @(posedge clk);
    if (r) begin
      hit_m  = '0;
      qual_m = '0;
    end else begin
      for (int c = 0; c < COLS; c++) begin
        int cnt = 0;
        for (int t = 0; t < TERMS; t++)
          if (terms[c*TERMS+t] && qual_m[c] && sd) cnt++;
        hit_m[c] = ei || (cnt > 0);
      end
      for (int c = 0; c < COLS; c++)
        if (we[c]) qual_m[c] = din[c];
    end
    @(negedge clk);
    check(req, hit_m);
  endtask

  initial begin
    logic [TB-1:0] ones;
    ones = '1;
    @(negedge clk);
    // R1: reset wins over override
    cyc(1, '1, '1, 1, 1, ones, "R1");
    check("R1", '0);
    // R8: write edge still uses old qualifier (0)
    cyc(0, 4'b1111, 4'b0101, 1, 0, ones, "R8");
    check("R8", 4'b0000);
    // R2: new qualifier visible next cycle
    cyc(0, '0, '0, 1, 0, ones, "R2");
    check("R2", 4'b0101);
    // R3: changing din with write low does nothing
    for (int k = 0; k < 3; k++) begin
      cyc(0, '0, 4'b1010, 1, 0, ones, "R3");
      check("R3", 4'b0101);
    end
    // R9: no terms returns to 0
    cyc(0, '0, '0, 1, 0, '0, "R9");
    check("R9", 4'b0000);
    // R5: select low blocks
    cyc(0, '0, '0, 0, 0, ones, "R5");
    check("R5", 4'b0000);
    // R7: override with select low and no terms
    cyc(0, '0, '0, 0, 1, '0, "R7");
    check("R7", 4'b1111);
    // R6: masked columns 1 and 3
    cyc(0, '0, '0, 1, 0, ones, "R6");
    check("R6", 4'b0101);
    // R10/R4: every single term position with all qualifiers set
    cyc(0, '1, '1, 0, 0, '0, "R2");
    for (int k = 0; k < TB; k++) begin
      logic [TB-1:0] one_hot;
      logic [COLS-1:0] exp;
      one_hot = '0; one_hot[k] = 1'b1;
      exp = '0; exp[k / TERMS] = 1'b1;
      cyc(0, '0, '0, 1, 0, one_hot, "R10");
      check("R10", exp);
    end
    // R4/R6/R5/R7: sweep qualifier patterns x select x override
    for (int q = 0; q < (1 << COLS); q++) begin
      cyc(0, '1, q[COLS-1:0], 0, 0, '0, "R2");
      for (int s = 0; s < 4; s++) begin
        logic [TB-1:0] rt;
        for (int b = 0; b < TB; b++) rt[b] = ($urandom % 8) == 0;
        cyc(0, '0, ~q[COLS-1:0], s[0], s[1], rt, "R4");
      end
    end
    // R3/R4: random traffic including writes and resets
    for (int n = 0; n < 3000; n++) begin
      logic [TB-1:0] rt;
      for (int b = 0; b < TB; b++) rt[b] = ($urandom % 10) == 0;
      cyc(($urandom % 97) == 0, $urandom, $urandom, ($urandom % 4) != 0,
          ($urandom % 9) == 0, rt, "R4");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule